// File: doc/BRIEF.md
# Initialization Block DMA Sequencer

This block copies a software initialization structure from host memory into a small local register file. It acts as a bus master. It uses short bus-ownership periods, called tenures, and each tenure reads exactly two DWords. After a tenure the block drops its request, which releases the bus, and then it asks for the bus again. A start pulse loads three things: the base address, a layout select (32-bit or 16-bit structure) and a burst-enable bit. When the last tenure ends, the block raises a done pulse. A data parity error on any read stops the sequence and raises an error pulse instead of done.

The 32-bit layout needs seven DWords, so it takes four tenures. The eighth DWord is read only to finish the last tenure, and it is thrown away. The 16-bit layout takes three tenures, which read six DWords, and all six are kept.

Burst mode and non-burst mode shape a tenure differently:
- In non-burst mode, every transfer has its own address phase, and the frame signal drops for one cycle between the two transfers.
- In burst mode, there is a single address phase with the burst flag set, and the frame signal stays high through both transfers.

The master interface is simple: a request/grant pair, a frame level, an address-phase strobe with its address and burst flag, and a data-valid input that carries a parity-error flag.

The controller is one state machine with these states:
- IDLE: waits for start. IDLE goes to REQ on a start pulse.
- REQ: holds the request. REQ goes to ADDR when grant is seen.
- ADDR: drives one address phase. ADDR always goes to DATA.
- DATA: waits for a transfer. DATA leaves on rd_valid:
  - on a parity error, it goes to ABORT;
  - after the first transfer of a tenure, it goes to GAP in non-burst mode, or stays in DATA in burst mode;
  - after the second transfer, it goes to DONE if this was the final tenure, and to REL otherwise.
- GAP: keeps the bus but drops frame. GAP goes to ADDR.
- REL: drops the request for one cycle. REL goes to REQ.
- DONE: pulses done. DONE goes to IDLE.
- ABORT: pulses err. ABORT goes to IDLE.

Top module: `ibfetch_seq`

## Requirements
- R1: After reset, bus_req, cmd_frame, cmd_addr_ph, busy, done and err are all 0, and every register-file slot reads 0.
- R2: Each tenure, from bus_req rising to bus_req falling, contains exactly two accepted transfers (rd_valid sampled while frame is high and address phase is low). bus_req is 0 in the cycle after the second transfer.
- R3: A run with layout32=1 makes four tenures. A run with layout32=0 makes three.
- R4: The address of each address phase is (base_addr with bits 1:0 forced to 0) + 4·n, where n is the number of transfers accepted so far in the run. Addresses therefore rise by 4, with no gaps, across tenures, and cmd_addr[1:0] is always 0.
- R5: With burst_en=0, a tenure has two address phases, and cmd_burst=0 in both. cmd_frame is 0 for at least one cycle between them while bus_req stays 1.
- R6: With burst_en=1, a tenure has one address phase, and cmd_burst=1 in it. cmd_frame stays 1 until both transfers are accepted, and cmd_addr[1:0]=0.
- R7: Register-file slot k (0 to 6) holds the k-th DWord of the run. In the 32-bit layout the eighth DWord is discarded, so slot 6 keeps DWord 6. A 16-bit run writes slots 0 to 5 and leaves slot 6 unchanged.
- R8: After a good run, done is 1 for exactly one cycle and err stays 0. Then busy and bus_req are 0.
- R9: If rd_perr is 1 on an accepted transfer:
  - err is 1 for one cycle and done is not raised;
  - the bus is released in the next cycle;
  - that DWord and all later DWords are not written.
- R10: A start pulse while busy=1 is ignored. The running sequence keeps its base, layout and burst mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when idle |
| layout32 | input | 1 | 1: 32-bit structure (4 tenures), 0: 16-bit (3 tenures) |
| burst_en | input | 1 | 1: burst tenures, 0: one address phase per transfer |
| base_addr | input | ADDR_W | Structure base byte address (bits 1:0 ignored) |
| bus_req | output | 1 | Bus request, held for the whole tenure |
| bus_gnt | input | 1 | Bus grant |
| cmd_frame | output | 1 | Frame level for address and data phases |
| cmd_addr_ph | output | 1 | Address-phase strobe |
| cmd_addr | output | ADDR_W | Byte address valid with cmd_addr_ph |
| cmd_burst | output | 1 | Linear burst flag in the address phase |
| rd_valid | input | 1 | Read data accepted this cycle |
| rd_data | input | DATA_W | Read data |
| rd_perr | input | 1 | Parity error on this read |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: run completed |
| err | output | 1 | One-cycle pulse: run aborted on parity error |
| rf_idx | input | 3 | Register-file read index |
| rf_data | output | DATA_W | Register-file read data |

## Verification
Most internal faults show up at the ports within one tenure:
- A wrong beat counter changes the number of transfers between request edges, or moves the frame drop.
- A wrong DWord index puts the wrong address on the very next address phase.
- A wrong tenure count ends the run early or late, which is seen when done arrives.

Register-file faults appear only after the run. They are read back through rf_idx: slot 6 catches a discarded eighth word that was wrongly kept, and the slots after an aborted transfer catch writes after the error.

// File: rtl/ibf_pkg.sv
package ibf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_GAP,
        ST_REL,
        ST_DONE,
        ST_ABORT
    } ibf_state_e;

endpackage

// File: rtl/ibf_fsm.sv
module ibf_fsm
    import ibf_pkg::*;
#(
    parameter int BEATS = 2,
    parameter int TEN_L = 4,
    parameter int TEN_S = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic layout32,
    input  logic burst_en,
    input  logic bus_gnt,
    input  logic rd_valid,
    input  logic rd_perr,
    output logic bus_req,
    output logic frame,
    output logic addr_ph,
    output logic burst_ph,
    output logic load,
    output logic beat_ok,
    output logic busy,
    output logic done,
    output logic err
);

    localparam int TEN_W  = $clog2(TEN_L + 1);
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    ibf_state_e state_q, state_d;
    logic [BEAT_W-1:0] beat_q;
    logic [TEN_W-1:0]  ten_q;
    logic [TEN_W-1:0]  ten_need;
    logic              layout_q, burst_q;
    logic              last_beat, last_ten;

    assign ten_need  = layout_q ? TEN_W'(TEN_L) : TEN_W'(TEN_S);
    assign last_beat = (beat_q == BEAT_W'(BEATS - 1));
    assign last_ten  = (ten_q == ten_need - TEN_W'(1));

    // state register and run counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            beat_q   <= '0;
            ten_q    <= '0;
            layout_q <= 1'b0;
            burst_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                beat_q   <= '0;
                ten_q    <= '0;
                layout_q <= layout32;
                burst_q  <= burst_en;
            end else if (beat_ok) begin
                if (last_beat) begin
                    beat_q <= '0;
                    ten_q  <= ten_q + TEN_W'(1);
                end else begin
                    beat_q <= beat_q + BEAT_W'(1);
                end
            end
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_REQ;
            ST_REQ:   if (bus_gnt) state_d = ST_ADDR;
            ST_ADDR:  state_d = ST_DATA;
            ST_DATA: begin
                if (rd_valid) begin
                    if (rd_perr)        state_d = ST_ABORT;
                    else if (!last_beat) state_d = burst_q ? ST_DATA : ST_GAP;
                    else if (last_ten)  state_d = ST_DONE;
                    else                state_d = ST_REL;
                end
            end
            ST_GAP:   state_d = ST_ADDR;
            ST_REL:   state_d = ST_REQ;
            ST_DONE:  state_d = ST_IDLE;
            ST_ABORT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        bus_req  = 1'b0;
        frame    = 1'b0;
        addr_ph  = 1'b0;
        burst_ph = 1'b0;
        done     = 1'b0;
        err      = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_REQ:   bus_req = 1'b1;
            ST_ADDR: begin
                bus_req  = 1'b1;
                frame    = 1'b1;
                addr_ph  = 1'b1;
                burst_ph = burst_q;
            end
            ST_DATA: begin
                bus_req = 1'b1;
                frame   = 1'b1;
            end
            ST_GAP:   bus_req = 1'b1;
            ST_REL:   ;
            ST_DONE:  done = 1'b1;
            ST_ABORT: err = 1'b1;
            default:  ;
        endcase
        busy    = (state_q != ST_IDLE);
        load    = (state_q == ST_IDLE) && start;
        beat_ok = (state_q == ST_DATA) && rd_valid && !rd_perr;
    end

    AST_TENURE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && last_beat) |=> !bus_req); // R2
    AST_BURST_ONE_APH: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && !last_beat && burst_q) |=> (frame && !addr_ph)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R8
    AST_ABORT_ON_PERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && rd_valid && rd_perr) |=> (err && !bus_req && !done)); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(layout_q) && $stable(burst_q))); // R10

endmodule

// File: rtl/ibf_addr.sv
module ibf_addr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              beat_ok,
    input  logic              addr_ph,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] cmd_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            base_q <= {base_addr[ADDR_W-1:2], 2'b00};
            idx_q  <= '0;
        end else if (beat_ok) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign idx      = idx_q;
    assign cmd_addr = base_q + (ADDR_W'(idx_q) << 2);

    AST_ADDR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ph |-> (cmd_addr[1:0] == 2'b00)); // R4
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && !load) |=> (idx_q == $past(idx_q) + IDX_W'(1))); // R4

endmodule

// File: rtl/ibf_regfile.sv
module ibf_regfile #(
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 4,
    parameter int NUM_SLOTS = 7,
    parameter int RD_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [RD_W-1:0]   rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slot_q [NUM_SLOTS];
    logic              keep;

    // indices past the last slot are surplus reads: dropped
    assign keep = we && (wr_idx < IDX_W'(NUM_SLOTS));

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (keep && (wr_idx == IDX_W'(g)))
                slot_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (rd_idx == RD_W'(i)) rd_data = slot_q[i];
    end

    AST_SURPLUS_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_idx >= IDX_W'(NUM_SLOTS)) |=> $stable(slot_q[NUM_SLOTS-1])); // R7

endmodule

// File: rtl/ibfetch_seq.sv
module ibfetch_seq #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int BEATS   = 2,
    parameter int TEN_L   = 4,
    parameter int TEN_S   = 3,
    parameter int SLOTS_L = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              layout32,
    input  logic              burst_en,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              cmd_frame,
    output logic              cmd_addr_ph,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_burst,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_perr,
    output logic              busy,
    output logic              done,
    output logic              err,
    input  logic [2:0]        rf_idx,
    output logic [DATA_W-1:0] rf_data
);

    localparam int IDX_W = $clog2(TEN_L * BEATS + 1);

    logic             load, beat_ok;
    logic [IDX_W-1:0] idx;

    ibf_fsm #(.BEATS(BEATS), .TEN_L(TEN_L), .TEN_S(TEN_S)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .layout32(layout32),
        .burst_en(burst_en), .bus_gnt(bus_gnt), .rd_valid(rd_valid),
        .rd_perr(rd_perr), .bus_req(bus_req), .frame(cmd_frame),
        .addr_ph(cmd_addr_ph), .burst_ph(cmd_burst), .load(load),
        .beat_ok(beat_ok), .busy(busy), .done(done), .err(err)
    );

    ibf_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .base_addr(base_addr),
        .beat_ok(beat_ok), .addr_ph(cmd_addr_ph), .idx(idx),
        .cmd_addr(cmd_addr)
    );

    ibf_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_SLOTS(SLOTS_L),
                  .RD_W(3)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(beat_ok), .wr_idx(idx),
        .wr_data(rd_data), .rd_idx(rf_idx), .rd_data(rf_data)
    );

endmodule

// File: tb/test_ibfetch_seq.sv
`timescale 1ns/1ps
module test_ibfetch_seq;

    logic        clk = 0, rst_n = 0;
    logic        start = 0, layout32 = 0, burst_en = 0;
    logic [31:0] base_addr = 0;
    logic        bus_req, bus_gnt = 0;
    logic        cmd_frame, cmd_addr_ph, cmd_burst;
    logic [31:0] cmd_addr;
    logic        rd_valid = 0, rd_perr = 0;
    logic [31:0] rd_data = 0;
    logic        busy, done, err;
    logic [2:0]  rf_idx = 0;
    logic [31:0] rf_data;

    ibfetch_seq i_ibfetch_seq (.*);

    always #5 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    logic [31:0] exp_base;
    logic        run_burst;
    int          beats_total, tenures, beats_in_ten, aph_in_ten;
    int          perr_at, done_cnt, err_cnt;
    logic        gap_seen, prev_req = 0;
    logic [31:0] exp_rf [7];

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // monitor and responder
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (done) done_cnt++;
            if (err) err_cnt++;
            if (bus_req && !prev_req) begin
                beats_in_ten = 0; aph_in_ten = 0; gap_seen = 0;
            end
            if (cmd_addr_ph) begin
                aph_in_ten++;
                chk(cmd_addr == exp_base + 32'(beats_total) * 4, "R4 address",
                    cmd_addr, exp_base + 32'(beats_total) * 4);
                chk(cmd_burst == run_burst, "R5/R6 burst flag",
                    32'(cmd_burst), 32'(run_burst));
                if (run_burst)
                    chk(cmd_addr[1:0] == 2'b00, "R6 linear low bits", 32'(cmd_addr[1:0]), 0);
            end
            if (bus_req && !cmd_frame && beats_in_ten == 1) gap_seen = 1;
            if (!bus_req && prev_req) begin
                if (!err) begin
                    tenures++;
                    chk(beats_in_ten == 2, "R2 transfers per tenure", beats_in_ten, 2);
                    chk(aph_in_ten == (run_burst ? 1 : 2), "R5/R6 address phases",
                        aph_in_ten, run_burst ? 1 : 2);
                    chk(gap_seen == !run_burst, "R5/R6 frame drop", 32'(gap_seen),
                        32'(!run_burst));
                end
            end
            prev_req = bus_req;
            bus_gnt = bus_req && ($urandom % 2 == 0);
            if (cmd_frame && !cmd_addr_ph && ($urandom % 3 != 0)) begin
                rd_valid = 1;
                rd_data = mem_word(exp_base + 32'(beats_total) * 4);
                rd_perr = (beats_total == perr_at);
                beats_total++; beats_in_ten++;
            end else begin
                rd_valid = 0; rd_perr = 0;
            end
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic check_rf(input string tag);
        for (int i = 0; i < 7; i++) begin
            rf_idx = 3'(i);
            #1;
            chk(rf_data == exp_rf[i], tag, rf_data, exp_rf[i]);
        end
    endtask

    task automatic run(input logic [31:0] base, input bit l32, input bit bst,
                       input int perr_beat, input bit mid_start);
        int need, wait_c;
        @(negedge clk);
        exp_base = base & ~32'h3; run_burst = bst;
        beats_total = 0; tenures = 0; done_cnt = 0; err_cnt = 0;
        perr_at = perr_beat;
        base_addr = base; layout32 = l32; burst_en = bst; start = 1;
        @(negedge clk);
        start = 0;
        wait_c = 0;
        while (!done && !err && wait_c < 2000) begin
            @(negedge clk);
            wait_c++;
            if (mid_start && wait_c == 8) begin
                // R10: restart attempt with other settings while busy
                base_addr = base + 32'h100; layout32 = !l32; burst_en = !bst; start = 1;
            end else start = 0;
        end
        start = 0;
        chk(wait_c < 2000, "R8 run completes", wait_c, 2000);
        repeat (3) @(negedge clk);
        need = l32 ? 7 : 6;
        if (perr_beat >= 0 && perr_beat < (l32 ? 8 : 6)) begin
            chk(err_cnt == 1, "R9 err pulse", err_cnt, 1);
            chk(done_cnt == 0, "R9 no done", done_cnt, 0);
            for (int i = 0; i < perr_beat && i < 7; i++) exp_rf[i] = mem_word(exp_base + 32'(i) * 4);
        end else begin
            chk(done_cnt == 1, "R8 done pulse", done_cnt, 1);
            chk(err_cnt == 0, "R8 no err", err_cnt, 0);
            chk(tenures == (l32 ? 4 : 3), "R3 tenure count", tenures, l32 ? 4 : 3);
            for (int i = 0; i < need; i++) exp_rf[i] = mem_word(exp_base + 32'(i) * 4);
        end
        chk(!busy && !bus_req, "R8 idle after run", {busy, bus_req}, 0);
        check_rf(l32 ? "R7 slots 32-bit" : "R7 slots 16-bit");
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 7; i++) exp_rf[i] = 0;
        #1;
        chk(!bus_req && !cmd_frame && !cmd_addr_ph && !busy && !done && !err,
            "R1 reset outputs", {bus_req, cmd_frame, cmd_addr_ph, busy, done, err}, 0);
        repeat (2) @(negedge clk);
        rst_n = 1;
        check_rf("R1 reset slots");
        // directed corners
        run(32'h0000_1000, 1, 0, -1, 0);
        run(32'h0000_2003, 0, 1, -1, 0);   // R4 base low bits ignored, slot 6 kept
        run(32'h0000_3000, 1, 1, -1, 0);
        run(32'h0000_4000, 0, 0, -1, 1);   // R10
        run(32'h0000_5000, 1, 1, 3, 0);    // R9 mid-run error
        run(32'h0000_6000, 1, 0, 7, 0);    // R9 error on surplus read
        run(32'h0000_7000, 1, 0, 0, 0);    // R9 error on first read
        // random runs
        for (int r = 0; r < 30; r++) begin
            bit l = 1'($urandom);
            int pb = ($urandom % 5 == 0) ? int'($urandom % (l ? 8 : 6)) : -1;
            run($urandom, l, 1'($urandom), pb, ($urandom % 4 == 0));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule